// File: doc/BRIEF.md
# Synchronizer Mode Controller

This block is the state machine that governs a telecom timing synchronizer. From a two-bit operating request, a reference choice, a recovery-style choice, an offset-keep input and the failure flag of the reference in use, it decides whether the phase-locked loop tracks its reference (Normal), coasts on remembered frequency (Holdover) or runs from the local oscillator alone (Freerun). It also decides when to pass through a short phase-offset measurement state (TIE correction) that makes recoveries and reference changes hitless.

Towards the phase-offset corrector the block issues three commands: a one-cycle measure strobe, a keep-stored-offset level and a clear-offset level. The clear command makes the output snap back into alignment with the reference. The loop arithmetic, the loop filter and clock synthesis sit elsewhere. Every output is a function of registers only, so each decision shows up one clock after the inputs that caused it.

Top module: `sync_mode_fsm`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `mode_ind` is 2'b10 (Freerun), `ref_idx` is 0, and `holdover`, `offs_meas`, `offs_keep` and `offs_clear` are all low.
- R2: `mode_ind` encodes 2'b00 Normal, 2'b01 Holdover, 2'b10 Freerun and 2'b11 TIE correction, and `holdover` is high exactly when `mode_ind` is 2'b01. A request of `mode_sel`=2'b01 gives Holdover one cycle later from any state. A request of 2'b10 or 2'b11 gives Freerun one cycle later from any state.
- R3: With `mode_sel`=2'b00, a Normal or TIE state with `ref_fail` high moves to Holdover in the next cycle. Holdover stays while `ref_fail` is high and is left once it clears.
- R4: In Freerun with `mode_sel`=2'b00, the block stays in Freerun while `ref_fail` is high. It starts the recovery of R5/R6 in the cycle after `ref_fail` is seen low.
- R5: When Holdover or Freerun is left for Normal while `hold_recover` or `offset_hold` is low, Normal is entered directly, with `offs_clear` high and `offs_keep` low in that first Normal cycle.
- R6: When the same departure happens with both `hold_recover` and `offset_hold` high, the block spends exactly 4 cycles in TIE correction. `offs_meas` is high in the first of those cycles only. It then enters Normal with `offs_keep` high and `offs_clear` low.
- R7: In Normal, a change of `ref_sel` with `offset_hold` high enters TIE correction in the next cycle, as in R6. With `offset_hold` low, the block remains in Normal with `offs_clear` high.
- R8: In every Normal cycle whose preceding input cycle had `offset_hold` low, `offs_clear` is high and `offs_keep` low. Otherwise, apart from the first cycle of R5, Normal shows `offs_keep` high and `offs_clear` low.
- R9: A change of `ref_sel` during TIE correction restarts the 4-cycle window, with a new `offs_meas` pulse in the next cycle.
- R10: `ref_idx` equals the `ref_sel` value sampled at the previous clock edge, in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Operating request: 00 auto Normal, 01 Holdover, 1x Freerun |
| ref_sel | input | 1 | Reference to track |
| hold_recover | input | 1 | High: recover through TIE correction |
| offset_hold | input | 1 | Low: discard the stored offset and align |
| ref_fail | input | 1 | Failure flag of the selected reference |
| mode_ind | output | 2 | Current state code |
| holdover | output | 1 | High in Holdover |
| ref_idx | output | 1 | Registered reference index |
| offs_meas | output | 1 | Measure-new-offset strobe |
| offs_keep | output | 1 | Keep stored offset |
| offs_clear | output | 1 | Clear offset and align to the reference |

## Verification
A wrong state register appears on `mode_ind` in the same cycle it is loaded, because the code is the state itself. A miscounted TIE window shows up one cycle early or late as a shifted return to 2'b00 and a shifted start of `offs_keep`. A stale clear flag inverts `offs_keep` and `offs_clear` in the first Normal cycle. Comparing against an independent model on every clock therefore exposes any such fault within one cycle of the transition that triggers it.

// File: rtl/sync_mode_fsm.sv
module sync_mode_fsm #(
  parameter int TIE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       ref_sel,
  input  logic       hold_recover,
  input  logic       offset_hold,
  input  logic       ref_fail,
  output logic [1:0] mode_ind,
  output logic       holdover,
  output logic       ref_idx,
  output logic       offs_meas,
  output logic       offs_keep,
  output logic       offs_clear
);

  localparam int CW = (TIE_CYCLES > 1) ? $clog2(TIE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIE_CYCLES - 1);

  typedef enum logic [1:0] {
    S_NORM = 2'b00,
    S_HOLD = 2'b01,
    S_FREE = 2'b10,
    S_TIE  = 2'b11
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt, nxt_cnt;
  logic clr_q, snap, sw, recov;

  assign sw    = ref_sel != ref_idx;
  assign recov = hold_recover && offset_hold;

  always_comb begin
    nxt     = st;
    nxt_cnt = '0;
    snap    = 1'b0;
    if (mode_sel[1]) nxt = S_FREE;
    else if (mode_sel[0]) nxt = S_HOLD;
    else begin
      case (st)
        S_FREE, S_HOLD:
          if (!ref_fail) begin
            if (recov) nxt = S_TIE;
            else begin
              nxt  = S_NORM;
              snap = 1'b1;
            end
          end
        S_NORM:
          if (ref_fail) nxt = S_HOLD;
          else if (sw) begin
            if (offset_hold) nxt = S_TIE;
            else snap = 1'b1;
          end
        S_TIE:
          if (ref_fail) nxt = S_HOLD;
          else if (sw) nxt_cnt = '0;
          else if (cnt == LAST) nxt = S_NORM;
          else nxt_cnt = cnt + 1'b1;
        default: nxt = S_FREE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_FREE;
      cnt     <= '0;
      ref_idx <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      st      <= nxt;
      cnt     <= nxt_cnt;
      ref_idx <= ref_sel;
      clr_q   <= (nxt == S_NORM) && (snap || !offset_hold);
    end
  end

  assign mode_ind   = st;
  assign holdover   = st == S_HOLD;
  assign offs_meas  = (st == S_TIE) && (cnt == '0);
  assign offs_keep  = (st == S_NORM) && !clr_q;
  assign offs_clear = clr_q;

  AST_FORCE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel[1] |=> mode_ind == 2'b10); // R2
  AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'b01 |=> holdover); // R2
  AST_FAIL_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && mode_ind == 2'b00 && ref_fail) |=> holdover); // R3
  AST_FREE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && mode_ind == 2'b10 && ref_fail) |=> mode_ind == 2'b10); // R4
  AST_SNAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && holdover && !ref_fail && !hold_recover) |=> (mode_ind == 2'b00 && offs_clear && !offs_keep)); // R5
  AST_MEAS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (offs_meas && mode_sel == 2'b00 && !ref_fail && ref_sel == ref_idx) |=> !offs_meas); // R6
  AST_REF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ref_idx == $past(ref_sel)); // R10

endmodule

// File: tb/test_sync_mode_fsm.sv
module test_sync_mode_fsm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b10;
  logic ref_sel = 1'b0, hold_recover = 1'b0, offset_hold = 1'b1, ref_fail = 1'b1;
  logic [1:0] mode_ind;
  logic holdover, ref_idx, offs_meas, offs_keep, offs_clear;

  sync_mode_fsm i_sync_mode_fsm (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_sel(ref_sel),
    .hold_recover(hold_recover), .offset_hold(offset_hold), .ref_fail(ref_fail),
    .mode_ind(mode_ind), .holdover(holdover), .ref_idx(ref_idx),
    .offs_meas(offs_meas), .offs_keep(offs_keep), .offs_clear(offs_clear));

  always #5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit cmp_on = 1'b0, done = 1'b0;
  string cur_req = "R1";

  // behavioural model: 0 Normal, 1 Holdover, 2 Freerun, 3 TIE
  int m_mode = 2, m_cnt = 0, m_ref = 0, nm, nc;
  bit m_clr = 1'b0, sn;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2; m_cnt = 0; m_ref = 0; m_clr = 1'b0;
    end else begin
      nm = m_mode; nc = 0; sn = 1'b0;
      if (mode_sel >= 2) nm = 2;
      else if (mode_sel == 1) nm = 1;
      else if (m_mode == 1 || m_mode == 2) begin
        if (!ref_fail) begin
          if (hold_recover && offset_hold) nm = 3;
          else begin nm = 0; sn = 1'b1; end
        end
      end else if (m_mode == 0) begin
        if (ref_fail) nm = 1;
        else if (int'(ref_sel) != m_ref) begin
          if (offset_hold) nm = 3; else sn = 1'b1;
        end
      end else begin
        if (ref_fail) nm = 1;
        else if (int'(ref_sel) != m_ref) nc = 0;
        else if (m_cnt == 3) nm = 0;
        else nc = m_cnt + 1;
      end
      m_clr  = (nm == 0) && (sn || !offset_hold);
      m_mode = nm;
      m_cnt  = nc;
      m_ref  = int'(ref_sel);
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      logic [1:0] e_mode;
      logic e_hold, e_ref, e_meas, e_keep, e_clr;
      e_mode = 2'(m_mode);
      e_hold = m_mode == 1;
      e_ref  = m_ref[0];
      e_meas = (m_mode == 3) && (m_cnt == 0);
      e_clr  = m_clr;
      e_keep = (m_mode == 0) && !m_clr;
      vectors++;
      if ({mode_ind, holdover, ref_idx, offs_meas, offs_keep, offs_clear} !==
          {e_mode, e_hold, e_ref, e_meas, e_keep, e_clr}) begin
        miscompares++;
        $display("FAIL %s t=%0t: mode=%b hold=%b ref=%b meas=%b keep=%b clr=%b, expected mode=%b hold=%b ref=%b meas=%b keep=%b clr=%b",
          cur_req, $time, mode_ind, holdover, ref_idx, offs_meas, offs_keep, offs_clear,
          e_mode, e_hold, e_ref, e_meas, e_keep, e_clr);
      end
    end
  end

  task automatic drive(input logic [1:0] ms, input logic rs, input logic hr,
                       input logic oh, input logic rf, input int n, input string tag);
    @(posedge clk); #2;
    mode_sel = ms; ref_sel = rs; hold_recover = hr; offset_hold = oh; ref_fail = rf;
    cur_req = tag;
    repeat (n - 1) @(posedge clk);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    cmp_on = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    drive(2'b10, 0, 0, 1, 1, 3, "R1");
    // Freerun waits for a good reference, then snaps to Normal
    drive(2'b00, 0, 0, 1, 1, 4, "R4");
    drive(2'b00, 0, 0, 1, 0, 4, "R5");
    // failure to holdover, hitless recovery
    drive(2'b00, 0, 1, 1, 1, 4, "R3");
    drive(2'b00, 0, 1, 1, 0, 8, "R6");
    // recovery with offset discarded although hitless style requested
    drive(2'b00, 0, 1, 1, 1, 3, "R3");
    drive(2'b00, 0, 1, 0, 0, 4, "R5");
    drive(2'b00, 0, 1, 0, 0, 4, "R8");
    drive(2'b00, 0, 1, 1, 0, 3, "R8");
    // reference switches in Normal
    drive(2'b00, 1, 1, 1, 0, 7, "R7");
    drive(2'b00, 0, 1, 0, 0, 3, "R7");
    drive(2'b00, 0, 1, 1, 0, 2, "R8");
    // switch restarts during TIE, and failure during TIE
    drive(2'b00, 1, 1, 1, 0, 2, "R7");
    drive(2'b00, 0, 1, 1, 0, 2, "R9");
    drive(2'b00, 1, 1, 1, 0, 7, "R9");
    drive(2'b00, 0, 1, 1, 0, 2, "R7");
    drive(2'b00, 0, 1, 1, 1, 3, "R3");
    // forced modes
    drive(2'b01, 0, 1, 1, 0, 3, "R2");
    drive(2'b10, 1, 1, 1, 0, 3, "R2");
    drive(2'b11, 0, 1, 1, 0, 3, "R2");
    drive(2'b00, 0, 1, 1, 0, 7, "R6");
    drive(2'b11, 0, 0, 1, 0, 2, "R2");
    // reference index follows in every state
    drive(2'b10, 1, 0, 1, 1, 2, "R10");
    drive(2'b01, 0, 0, 1, 1, 2, "R10");
    drive(2'b01, 1, 0, 1, 1, 2, "R10");
    drive(2'b00, 1, 0, 1, 0, 4, "R5");
    // mid-run reset
    @(posedge clk); #2 rst_n = 1'b0; cur_req = "R1";
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    drive(2'b00, 1, 0, 1, 1, 3, "R4");
    drive(2'b00, 1, 1, 1, 0, 8, "R6");
    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual hung, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule